// File: doc/BRIEF.md
# Thermal Status Latch with Fire Interlock

This block keeps a sticky over-temperature flag for each of four firing channels and blocks the fire enable of any channel whose flag is set. A raw thermal-limit input sets the channel's flag within one clock. The flag then stays set until the host has read it over the serial link and a later frame has carried that data out.

The serial link is seen only through four inputs: an active-low chip select, a one-cycle strobe per serial clock edge, and a decoded status-read strobe. A frame is valid when exactly eight clock-edge strobes arrive between the falling and the rising edge of chip select. A valid frame that carries the status-read command takes a snapshot of the four flags. The snapshot is the readout value. The next valid frame, whatever command it carries, transmits that snapshot. At that frame's chip-select rise, the channels in the snapshot are cleared. A thermal event seen during the transmitting frame is kept and sets its flag again after the clear.

A small state machine tracks the report cycle. In ST_IDLE no snapshot is waiting. The transition IDLE_TO_ARMED happens on a valid read frame. In ST_ARMED a snapshot is waiting for its transmit frame, and ARMED_TO_XMIT happens on the falling edge of chip select. In ST_XMIT the transmit frame is in progress, and three transitions leave it at the chip-select rise:
- XMIT_TO_IDLE on a valid frame that is not a read frame.
- XMIT_TO_ARMED_RESNAP on a valid read frame, which clears and then takes a fresh snapshot.
- XMIT_TO_ARMED_RETRY on an invalid frame, which clears nothing.

Chip select and both strobes are synchronous to `clk`.

Top module: `thermal_interlock`

## Requirements
- R1: After reset every thermal flag is 0, `therm_stat` is 4'h0, and `fire_en` equals `fire_req`.
- R2: A 1 on `therm_raw[i]` sets flag i at the next clock edge. The flag stays set after `therm_raw[i]` returns to 0.
- R3: At the chip-select rise of a valid frame that saw `rd_cmd`, `therm_stat` (bit i is channel i) takes the value of the flags, with the raw inputs of that cycle included. The new value is visible one clock later.
- R4: At the chip-select rise of the next valid frame, the flags of the channels set in the snapshot are cleared, and the fire enables of those channels follow `fire_req` again.
- R5: A frame with a clock-edge count other than 8 neither takes a snapshot nor clears a flag, and `therm_stat` is unchanged.
- R6: A raw thermal event seen while the transmitting frame's chip select is low leaves that channel's flag set after the clear.
- R7: `fire_en[i]` is `fire_req[i]` when flag i is 0 and 0 when flag i is 1, independent of the other channels.
- R8: A valid read frame used as the transmit frame clears the reported flags and then snapshots the flags that remain into `therm_stat`.
- R9: A flag set after the snapshot was taken, and absent from it, is not cleared by the transmit frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| therm_raw | input | 4 | Raw thermal-limit flags, one per channel |
| cs_n | input | 1 | Serial chip select, active low |
| sclk_pulse | input | 1 | One-cycle strobe per serial clock edge |
| rd_cmd | input | 1 | Decoded status-read command strobe |
| fire_req | input | 4 | Per-channel arm/fire requests |
| therm_stat | output | 4 | Snapshot of the thermal flags for readout |
| fire_en | output | 4 | Gated per-channel fire enables |

## Verification
The full read, transmit and clear cycle is run once for each of the 16 raw thermal patterns. This shows that every channel combination is captured, blocks only its own channels, and is released exactly by the transmit frame. Frames with 7 and 9 edges are set against 8-edge frames to separate valid frames from invalid ones, both for capture and for clear. Events injected during the transmit frame, and between the snapshot and the transmit frame, separate "clear only what was reported" from a blanket clear. A read frame used as the transmit frame checks the clear-then-resnap order. Finally, all 16 request patterns are swept with two flags set to confirm that the channels are gated independently.

// File: rtl/thermil_pkg.sv
package thermil_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_XMIT  = 2'd2
    } rpt_state_e;
endpackage

// File: rtl/thermil_frame_mon.sv
module thermil_frame_mon #(
    parameter int FRAME_EDGES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk_pulse,
    input  logic rd_cmd,
    output logic frame_start,
    output logic frame_end_ok,
    output logic frame_end_bad,
    output logic frame_is_rd
);
    localparam int CW = $clog2(FRAME_EDGES + 2);
    localparam logic [CW-1:0] CNT_SAT = CW'(FRAME_EDGES + 1);
    localparam logic [CW-1:0] CNT_OK  = CW'(FRAME_EDGES);

    logic          cs_q;
    logic [CW-1:0] edge_cnt;
    logic          rd_seen;
    logic          frame_end;

    assign frame_start   = cs_q & ~cs_n;
    assign frame_end     = ~cs_q & cs_n;
    assign frame_end_ok  = frame_end && (edge_cnt == CNT_OK);
    assign frame_end_bad = frame_end && (edge_cnt != CNT_OK);
    assign frame_is_rd   = rd_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q     <= 1'b1;
            edge_cnt <= '0;
            rd_seen  <= 1'b0;
        end else begin
            cs_q <= cs_n;
            if (frame_start) begin
                edge_cnt <= sclk_pulse ? CW'(1) : '0;
                rd_seen  <= rd_cmd;
            end else if (!cs_n) begin
                if (sclk_pulse && edge_cnt != CNT_SAT)
                    edge_cnt <= edge_cnt + 1'b1;
                if (rd_cmd)
                    rd_seen <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/thermil_flag_bank.sv
module thermil_flag_bank #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] raw,
    input  logic           cs_n,
    input  logic           frame_start,
    input  logic           clr_en,
    input  logic [NCH-1:0] clr_mask,
    output logic [NCH-1:0] flags,
    output logic [NCH-1:0] seen,
    output logic [NCH-1:0] flags_nxt
);
    // Events inside the current frame survive a clear at its end.
    always_comb begin
        if (clr_en)
            flags_nxt = (flags & ~clr_mask) | seen | raw;
        else
            flags_nxt = flags | raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
            seen  <= '0;
        end else begin
            flags <= flags_nxt;
            if (frame_start)
                seen <= raw;
            else if (!cs_n)
                seen <= seen | raw;
        end
    end
endmodule

// File: rtl/thermil_fire_gate.sv
module thermil_fire_gate #(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0] fire_req,
    input  logic [NCH-1:0] flags,
    output logic [NCH-1:0] fire_en
);
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        assign fire_en[ch] = fire_req[ch] & ~flags[ch];
    end
endmodule

// File: rtl/thermal_interlock.sv
module thermal_interlock
    import thermil_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int FRAME_EDGES = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] therm_raw,
    input  logic           cs_n,
    input  logic           sclk_pulse,
    input  logic           rd_cmd,
    input  logic [NCH-1:0] fire_req,
    output logic [NCH-1:0] therm_stat,
    output logic [NCH-1:0] fire_en
);
    rpt_state_e     state, state_nxt;
    logic           frame_start, end_ok, end_bad, is_rd;
    logic           clr_en;
    logic [NCH-1:0] sticky, seen, sticky_nxt, snap;

    thermil_frame_mon #(.FRAME_EDGES(FRAME_EDGES)) u_mon (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk_pulse(sclk_pulse),
        .rd_cmd(rd_cmd), .frame_start(frame_start),
        .frame_end_ok(end_ok), .frame_end_bad(end_bad), .frame_is_rd(is_rd)
    );

    assign clr_en = (state == ST_XMIT) && end_ok;

    thermil_flag_bank #(.NCH(NCH)) u_flags (
        .clk(clk), .rst_n(rst_n), .raw(therm_raw), .cs_n(cs_n),
        .frame_start(frame_start), .clr_en(clr_en), .clr_mask(snap),
        .flags(sticky), .seen(seen), .flags_nxt(sticky_nxt)
    );

    thermil_fire_gate #(.NCH(NCH)) u_gate (
        .fire_req(fire_req), .flags(sticky), .fire_en(fire_en)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (end_ok && is_rd) state_nxt = ST_ARMED;   // IDLE_TO_ARMED
            ST_ARMED: if (frame_start)     state_nxt = ST_XMIT;    // ARMED_TO_XMIT
            ST_XMIT: begin
                if (end_ok)  state_nxt = is_rd ? ST_ARMED : ST_IDLE; // RESNAP / TO_IDLE
                if (end_bad) state_nxt = ST_ARMED;                   // RETRY
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Output register: readout snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            snap <= '0;
        else if (end_ok && is_rd && state != ST_ARMED)
            snap <= sticky_nxt;
    end

    assign therm_stat = snap;
endmodule

module thermal_interlock_chk
    import thermil_pkg::*;
#(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input rpt_state_e     state,
    input logic           end_ok,
    input logic           end_bad,
    input logic           is_rd,
    input logic [NCH-1:0] therm_raw,
    input logic [NCH-1:0] sticky,
    input logic [NCH-1:0] seen,
    input logic [NCH-1:0] snap,
    input logic [NCH-1:0] fire_en
);
    // R2
    raw_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|therm_raw) |=> ((sticky & $past(therm_raw)) == $past(therm_raw)));

    // R7
    hot_channel_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fire_en & sticky) == '0));

    // R3
    read_snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && end_ok && is_rd) |=> (snap == $past(sticky | therm_raw)));

    // R5
    bad_frame_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_bad |=> $stable(snap));

    // R5
    bad_frame_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_bad |=> ((sticky & $past(sticky)) == $past(sticky)));

    // R6
    frame_event_survives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XMIT && end_ok) |=>
            ((sticky & $past(seen | therm_raw)) == $past(seen | therm_raw)));
endmodule

bind thermal_interlock thermal_interlock_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .end_ok(end_ok),
    .end_bad(end_bad), .is_rd(is_rd), .therm_raw(therm_raw),
    .sticky(sticky), .seen(seen), .snap(snap), .fire_en(fire_en)
);

// File: tb/thermal_interlock_test.sv
module thermal_interlock_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] therm_raw = '0;
    logic       cs_n = 1'b1;
    logic       sclk_pulse = 1'b0;
    logic       rd_cmd = 1'b0;
    logic [3:0] fire_req = 4'hF;
    logic [3:0] therm_stat, fire_en;
    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    thermal_interlock uut (
        .clk(clk), .rst_n(rst_n), .therm_raw(therm_raw), .cs_n(cs_n),
        .sclk_pulse(sclk_pulse), .rd_cmd(rd_cmd), .fire_req(fire_req),
        .therm_stat(therm_stat), .fire_en(fire_en)
    );

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic pulse_raw(input logic [3:0] v);
        @(negedge clk) therm_raw = v;
        @(negedge clk) therm_raw = '0;
        @(negedge clk);
    endtask

    // One frame: edges strobes, optional read strobe, optional raw event inside
    task automatic frame(input int edges, input bit rd, input logic [3:0] ev);
        @(negedge clk) cs_n = 1'b0;
        @(negedge clk);
        for (int k = 0; k < edges; k++) begin
            sclk_pulse = 1'b1;
            @(negedge clk) sclk_pulse = 1'b0;
            @(negedge clk);
        end
        if (rd) begin
            rd_cmd = 1'b1;
            @(negedge clk) rd_cmd = 1'b0;
        end
        if (ev != 0) begin
            therm_raw = ev;
            @(negedge clk) therm_raw = '0;
        end
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 stat", therm_stat, 4'h0);
        chk("R1 fire", fire_en, 4'hF);

        // Exhaustive pattern sweep of the read/transmit/clear cycle
        for (int p = 0; p < 16; p++) begin
            pulse_raw(4'(p));
            chk("R2 sticky block", fire_en, ~4'(p));
            frame(8, 1'b1, 4'h0);
            chk("R3 snapshot", therm_stat, 4'(p));
            frame(8, 1'b0, 4'h0);
            chk("R4 cleared", fire_en, 4'hF);
            chk("R4 stat kept", therm_stat, 4'(p));
        end

        // R5: invalid frames
        pulse_raw(4'h5);
        frame(7, 1'b1, 4'h0);
        chk("R5 short read ignored", therm_stat, 4'hF);
        frame(9, 1'b1, 4'h0);
        chk("R5 long read ignored", therm_stat, 4'hF);
        frame(8, 1'b1, 4'h0);
        chk("R3 valid read", therm_stat, 4'h5);
        frame(9, 1'b0, 4'h0);
        chk("R5 long nop no clear", fire_en, 4'hA);
        frame(7, 1'b0, 4'h0);
        chk("R5 short nop no clear", fire_en, 4'hA);
        frame(8, 1'b0, 4'h0);
        chk("R4 clear after retry", fire_en, 4'hF);

        // R6: event during transmit frame
        pulse_raw(4'h1);
        frame(8, 1'b1, 4'h0);
        frame(8, 1'b0, 4'h1);
        chk("R6 event kept", fire_en, 4'hE);
        frame(8, 1'b1, 4'h0);
        chk("R6 reread", therm_stat, 4'h1);
        frame(8, 1'b0, 4'h0);
        chk("R6 finally cleared", fire_en, 4'hF);

        // R9: flag set after snapshot survives
        pulse_raw(4'h2);
        frame(8, 1'b1, 4'h0);
        chk("R9 snap", therm_stat, 4'h2);
        pulse_raw(4'h4);
        frame(8, 1'b0, 4'h0);
        chk("R9 unreported kept", fire_en, 4'hB);
        frame(8, 1'b1, 4'h0);
        chk("R9 reread", therm_stat, 4'h4);
        frame(8, 1'b0, 4'h0);
        chk("R9 cleared", fire_en, 4'hF);

        // R8: read frame as transmit frame
        pulse_raw(4'h8);
        frame(8, 1'b1, 4'h0);
        chk("R8 first snap", therm_stat, 4'h8);
        frame(8, 1'b1, 4'h1);
        chk("R8 resnap", therm_stat, 4'h1);
        chk("R8 fire", fire_en, 4'hE);
        frame(8, 1'b0, 4'h0);
        chk("R8 cleared", fire_en, 4'hF);

        // R7: per-channel gating with flags 0011
        pulse_raw(4'h3);
        for (int r = 0; r < 16; r++) begin
            @(negedge clk) fire_req = 4'(r);
            @(negedge clk);
            chk("R7 gate", fire_en, 4'(r) & 4'hC);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule